// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM Controller

This block is the synchronous control path of a pipelined static RAM. Reads and writes can follow each other on consecutive clocks with no idle cycle between them. On every enabled rising edge it samples a chip select, a write strobe, per-byte write enables, a load/advance select and an address. From these it builds one access command. Commands pass through a two-stage pipeline. Read data leaves a registered output, and the block produces the drive enable for the shared data bus.

The write path is delayed so that a write's data arrives in the same bus slot in which a read's data would leave. Because of this, a change of direction never needs a dead cycle. A load cycle starts a new access at an external address. An advance cycle steps a two-bit burst counter through up to four locations, in either linear or interleaved order. An active-low clock enable freezes the whole pipeline. A read of a location whose write data is still on its way returns that data, merged byte by byte with the stored word. The storage array is a small behavioural register array.

Top module: `zt_sram_core`

## Requirements
- R1: During and after synchronous reset, `dq_oe` is low, `rdata` is zero, no access is pending and the array holds zeros.
- R2: An enabled edge with `adv_ld` low and `ce_n` low loads a new access at `addr`: a read when `we_n` is high, a write when it is low. Read data appears on `rdata` after the next enabled edge and stays there until another read replaces it.
- R3: Write data on `wdata` is sampled at the second enabled edge after its command, which is the same slot as a read's data. Bit i of `byte_we_n` (active low) guards bits 8i+7..8i. With all bits high, nothing is written.
- R4: An enabled edge with `adv_ld` high and an access active continues the burst. The direction stays the same, address bits above bit 1 are held, and only the two low bits step. After the fourth access the order wraps.
- R5: When `burst_mode` was 0 at the load, the low two address bits of the n-th access are (start + n) mod 4.
- R6: When `burst_mode` was 1 at the load, the low two address bits of the n-th access are start XOR n.
- R7: While `clk_en_n` is high, rising edges are ignored. Pipeline, burst state, `rdata`, `dq_oe` and the array all hold, and `wdata` is not sampled.
- R8: An enabled edge with `adv_ld` low and `ce_n` high deselects the block. If the next edge is also enabled, `dq_oe` is low after it.
- R9: An advance edge while deselected leaves the block deselected, whatever `ce_n` is.
- R10: `dq_oe` is high only while the current data slot belongs to a read and `oe_n` is low. It is low during every write's data slot.
- R11: A read whose address matches the write currently in its data slot returns `wdata` for the enabled bytes of that write and the stored bytes for the others.
- R12: Reads and writes may alternate on every enabled edge, and each access keeps its own data slot with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| ce_n | input | 1 | Chip select, active low, sampled on load cycles |
| we_n | input | 1 | Write strobe, active low, sampled on load cycles |
| adv_ld | input | 1 | 0 loads a new address and command, 1 advances the burst |
| burst_mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| byte_we_n | input | 2 | Per-byte write enables, active low, sampled every enabled edge |
| addr | input | 6 | Word address |
| wdata | input | 16 | Write data for the write in its data slot |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 16 | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
A read loaded at enabled edge k puts its data on `rdata`, and raises `dq_oe`, right after enabled edge k+1. A write loaded at edge k takes `wdata` at edge k+2. Frozen edges push each of these deadlines back by one per frozen edge. The bench advances a behavioural model on every rising edge with the inputs that were applied for that edge. It then compares `rdata` and `dq_oe` at the following falling edge, so each result is checked in the cycle it becomes due and in every cycle where it must hold. The model applies a pending write before it serves the read in the same edge, which gives the merge behaviour of R11 without copying the forwarding logic.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
    parameter int ADDR_W  = 6;
    parameter int BYTE_W  = 8;
    parameter int BYTES   = 2;
    parameter int DATA_W  = BYTES * BYTE_W;
    parameter int DEPTH   = 1 << ADDR_W;
    parameter int BURST_W = 2;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTES-1:0]  be_n;
    } cmd_t;

    // low address bits of a burst access: linear add or interleaved xor
    function automatic logic [BURST_W-1:0] burst_lo(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               interleave
    );
        return interleave ? (start ^ step) : BURST_W'(start + step);
    endfunction
endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
    import zt_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              adv_ld,
    input  logic              burst_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTES-1:0]  byte_we_n,
    output cmd_t              cmd
);
    logic               active;
    logic               wr_q;
    logic               mode_q;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] step_q;
    logic [BYTES-1:0]   be_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            wr_q   <= 1'b0;
            mode_q <= 1'b0;
            base_q <= '0;
            step_q <= '0;
            be_q   <= '1;
        end else if (en) begin
            be_q <= byte_we_n;
            if (!adv_ld) begin
                if (ce_n) begin
                    active <= 1'b0;
                end else begin
                    active <= 1'b1;
                    wr_q   <= !we_n;
                    mode_q <= burst_mode;
                    base_q <= addr;
                    step_q <= '0;
                end
            end else if (active) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    always_comb begin
        cmd.valid = active;
        cmd.wr    = wr_q;
        cmd.addr  = {base_q[ADDR_W-1:BURST_W],
                     burst_lo(base_q[BURST_W-1:0], step_q, mode_q)};
        cmd.be_n  = be_q;
    end

    // R4
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && adv_ld && active) |=>
            (active && wr_q == $past(wr_q) &&
             cmd.addr[ADDR_W-1:BURST_W] == $past(cmd.addr[ADDR_W-1:BURST_W])));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && adv_ld && active && !mode_q) |=>
            (cmd.addr[BURST_W-1:0] == BURST_W'($past(cmd.addr[BURST_W-1:0]) + 1'b1)));

    // R8
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !adv_ld && ce_n) |=> !cmd.valid);

    // R9
    cont_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (en && adv_ld && !active) |=> !cmd.valid);
endmodule

// File: rtl/zt_sram_store.sv
module zt_sram_store
    import zt_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  cmd_t              wr_cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] fwd;
    logic              hit;
    logic              commit;

    assign commit = wr_cmd.valid && wr_cmd.wr;
    assign hit    = commit && (wr_cmd.addr == rd_addr);

    // per-byte merge of the write in its data slot with stored contents
    for (genvar b = 0; b < BYTES; b++) begin : g_merge
        assign fwd[b*BYTE_W +: BYTE_W] = (hit && !wr_cmd.be_n[b])
                                       ? wdata[b*BYTE_W +: BYTE_W]
                                       : mem[rd_addr][b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else if (en) begin
            if (commit) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (!wr_cmd.be_n[b])
                        mem[wr_cmd.addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
                end
            end
            if (rd_en) rdata <= fwd;
        end
    end

    // R3
    byte_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (en && commit && wr_cmd.be_n == '0) |=>
            (mem[$past(wr_cmd.addr)] == $past(wdata)));
endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
    import zt_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              adv_ld,
    input  logic              burst_mode,
    input  logic [BYTES-1:0]  byte_we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              dq_oe
);
    logic en;
    cmd_t s1;
    cmd_t s2;

    assign en = !clk_en_n;

    zt_burst_gen u_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .adv_ld     (adv_ld),
        .burst_mode (burst_mode),
        .addr       (addr),
        .byte_we_n  (byte_we_n),
        .cmd        (s1)
    );

    // data-slot stage: the command whose data is on the bus now
    always_ff @(posedge clk) begin
        if (rst)     s2 <= '0;
        else if (en) s2 <= s1;
    end

    zt_sram_store u_store (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .rd_en   (s1.valid && !s1.wr),
        .rd_addr (s1.addr),
        .wr_cmd  (s2),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    assign dq_oe = s2.valid && !s2.wr && !oe_n;

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(rdata) && $stable(s2)));

    // R10
    wr_phase_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !adv_ld && !ce_n && !we_n ##1 !clk_en_n) |=> !dq_oe);

    // R8
    desel_float_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !adv_ld && ce_n ##1 !clk_en_n) |=> !dq_oe);
endmodule

// File: tb/zt_sram_core_bench.sv
module zt_sram_core_bench;
    import zt_sram_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clk_en_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              we_n = 1'b1;
    logic              adv_ld = 1'b0;
    logic              burst_mode = 1'b0;
    logic [BYTES-1:0]  byte_we_n = '1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              oe_n = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              dq_oe;

    always #4 clk = ~clk;

    zt_sram_core u_zt_sram_core (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .ce_n(ce_n), .we_n(we_n),
        .adv_ld(adv_ld), .burst_mode(burst_mode), .byte_we_n(byte_we_n),
        .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .dq_oe(dq_oe)
    );

    typedef struct packed {
        bit       v;
        bit       wr;
        int       a;
        bit [1:0] be;
    } mcmd_t;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string tag = "R1";

    logic [DATA_W-1:0] m_mem [DEPTH];
    logic [DATA_W-1:0] exp_rdata;
    mcmd_t p0, p1;
    bit m_active, m_wr, m_mode;
    int m_base, m_step;

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
            exp_rdata = '0; p0 = '0; p1 = '0;
            m_active = 0; m_wr = 0; m_mode = 0; m_base = 0; m_step = 0;
        end else if (!clk_en_n) begin
            // the write in its data slot lands before the read is served
            if (p1.v && p1.wr)
                for (int b = 0; b < BYTES; b++)
                    if (!p1.be[b]) m_mem[p1.a][b*8 +: 8] = wdata[b*8 +: 8];
            if (p0.v && !p0.wr) exp_rdata = m_mem[p0.a];
            p1 = p0;
            if (!adv_ld) begin
                if (ce_n) m_active = 0;
                else begin
                    m_active = 1; m_wr = !we_n; m_base = int'(addr);
                    m_step = 0; m_mode = burst_mode;
                end
            end else if (m_active) begin
                m_step = (m_step + 1) % 4;
            end
            p0.v  = m_active;
            p0.wr = m_wr;
            p0.a  = (m_base & ~3) | (m_mode ? ((m_base & 3) ^ m_step)
                                            : ((m_base + m_step) & 3));
            p0.be = byte_we_n;
        end
    endtask

    task automatic compare();
        bit exp_oe;
        exp_oe = p1.v && !p1.wr && !oe_n;
        checks++;
        if (dq_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s dq_oe cycle %0d got %0b exp %0b", tag, cyc, dq_oe, exp_oe);
        end
        checks++;
        if (rdata !== exp_rdata) begin
            fails++;
            $display("FAIL %s rdata cycle %0d got %h exp %h", tag, cyc, rdata, exp_rdata);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic drive(input bit cen, input bit ce, input bit we, input bit adv,
                         input bit mode, input bit [1:0] be, input int a, input bit oe);
        clk_en_n = cen; ce_n = ce; we_n = we; adv_ld = adv; burst_mode = mode;
        byte_we_n = be; addr = ADDR_W'(a); oe_n = oe;
        wdata = DATA_W'(cyc * 16'h1357 + 16'h00a5);
        step();
    endtask

    task automatic desel(input int n);
        for (int i = 0; i < n; i++) drive(0, 1, 1, 0, 0, 2'b11, 0, 0);
    endtask

    task automatic adv(input int n, input bit [1:0] be);
        for (int i = 0; i < n; i++) drive(0, 1, 1, 1, 0, be, 0, 0);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        // R1: reset state at the ports
        checks++;
        if (dq_oe !== 1'b0 || rdata !== '0) begin
            fails++;
            $display("FAIL R1 reset got oe=%0b rdata=%h exp oe=0 rdata=0000", dq_oe, rdata);
        end
        desel(2);

        tag = "R2 R3 R4 R5 linear write burst";
        drive(0, 0, 0, 0, 0, 2'b00, 10, 0);
        adv(3, 2'b00);
        desel(2);
        tag = "R2 R4 R5 R10 linear read burst";
        drive(0, 0, 1, 0, 0, 2'b11, 10, 0);
        adv(3, 2'b11);
        desel(2);

        tag = "R6 interleaved write and reads";
        drive(0, 0, 0, 0, 1, 2'b00, 21, 0);
        adv(3, 2'b00);
        desel(2);
        drive(0, 0, 1, 0, 1, 2'b11, 21, 0);
        adv(3, 2'b11);
        drive(0, 0, 1, 0, 0, 2'b11, 22, 0);
        adv(3, 2'b11);
        desel(2);

        tag = "R3 byte enables";
        drive(0, 0, 0, 0, 0, 2'b00, 30, 0);
        drive(0, 0, 0, 0, 0, 2'b10, 30, 0);
        drive(0, 0, 0, 0, 0, 2'b11, 30, 0);
        drive(0, 0, 0, 0, 0, 2'b01, 31, 0);
        desel(2);
        drive(0, 0, 1, 0, 0, 2'b11, 30, 0);
        drive(0, 0, 1, 0, 0, 2'b11, 31, 0);
        desel(2);

        tag = "R11 R12 alternating with forwarding";
        for (int i = 0; i < 8; i++) begin
            drive(0, 0, 0, 0, 0, (i % 3 == 0) ? 2'b01 : 2'b00, 40 + (i % 2), 0);
            drive(0, 0, 1, 0, 0, 2'b11, 40 + (i % 2), 0);
        end
        desel(2);

        tag = "R7 clock enable freeze";
        drive(0, 0, 1, 0, 0, 2'b11, 10, 0);
        adv(1, 2'b11);
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, 1, 2'b00, 50 + i, i % 2);
        adv(2, 2'b11);
        drive(0, 0, 0, 0, 0, 2'b00, 12, 0);
        drive(1, 0, 1, 0, 0, 2'b00, 33, 0);
        drive(1, 1, 1, 1, 0, 2'b00, 34, 0);
        adv(1, 2'b00);
        drive(1, 0, 1, 0, 0, 2'b11, 0, 0);
        desel(2);
        drive(0, 0, 1, 0, 0, 2'b11, 12, 0);
        desel(2);

        tag = "R8 R9 deselect and continue";
        drive(0, 0, 1, 0, 0, 2'b11, 10, 0);
        drive(0, 1, 1, 0, 0, 2'b11, 0, 0);
        drive(0, 0, 0, 1, 0, 2'b00, 0, 0);
        drive(0, 0, 1, 1, 0, 2'b00, 0, 0);
        drive(0, 0, 1, 0, 0, 2'b11, 11, 0);
        desel(2);

        tag = "R4 burst wrap";
        drive(0, 0, 1, 0, 0, 2'b11, 9, 0);
        adv(6, 2'b11);
        drive(0, 0, 1, 0, 1, 2'b11, 23, 1);
        adv(5, 2'b11);
        desel(2);

        tag = "R10 R12 mixed traffic";
        for (int i = 0; i < 600; i++) begin
            drive(($urandom % 6) == 0, ($urandom % 5) == 0, $urandom % 2,
                  ($urandom % 3) == 0, $urandom % 2, 2'($urandom),
                  int'($urandom % 16) + 8, ($urandom % 7) == 0);
        end
        desel(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule